// File: doc/BRIEF.md
# Periodic Interrupt Down-Counter

This block is a 32-bit timer that counts down and sits on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. Software writes a start value, a compare value and a control word. The counter then decrements once per divided tick. The tick comes from one of two clock-enable inputs, a fast one and a slow one, selected by a field in the control word. That tick is divided by a 12-bit prescaler. When the count passes through zero it either reloads from the load register or wraps to all ones. A sticky compare flag is raised when the count steps onto the compare value. That flag, gated by an interrupt-enable bit, drives a level interrupt.

A two-state machine governs counting. HALT holds the count. The transition START (an enable write arriving while halted) enters RUN. RUN decrements on each divided tick. The transition STOP (a control write that clears enable, or any soft-reset write) returns to HALT. Hardware reset enters HALT. Byte offsets of the registers: control 0x00, status 0x04, load 0x08, compare 0x0C, live count 0x10 (read-only).

Top module: `periodic_irq_timer`

## Requirements
- R1: After hardware reset, control, status, compare and count read 0, load reads 0xFFFFFFFF, and `irq` is low.
- R2: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 return 0. Writes to those offsets, and writes to the count at 0x10, change no register.
- R3: Control fields: bit 0 enable, bit 1 fresh-start, bit 2 compare interrupt enable, bit 3 reload mode, bits 15:4 prescaler, bit 16 soft reset, bit 17 immediate overwrite, bits 21:18 freeze bits (stored, no effect), bits 25:24 source select. Only bits 25:0 are stored, and bit 16 always reads 0.
- R4: In RUN, each divided tick moves the count down by one. A tick at count 0 loads the load register when reload mode is 1, and 0xFFFFFFFF when it is 0.
- R5: Source select 00 gives no ticks. Values 01 and 10 count pulses of `fast_tick_en`. Value 11 counts pulses of `slow_tick_en`.
- R6: With prescaler value P, the count moves once per P+1 source pulses. Every control write restarts the division.
- R7: A control write that raises enable with fresh-start = 1 sets the count to the load value if the written reload mode is 1, else to 0xFFFFFFFF. With fresh-start = 0 the held count resumes. While disabled the count holds.
- R8: A load write while immediate overwrite (bit 17) is 1 copies the written value into the count at once. Without that bit, the count is untouched.
- R9: Status bit 0 is set on the tick that moves the count onto the compare value, so a compare of 0 fires on reaching zero. It stays set until status is written with bit 0 = 1. Writing 0 has no effect. A set and a clear in the same cycle leave it set.
- R10: `irq` is high exactly while status bit 0 and control bit 2 are both 1.
- R11: A control write with bit 16 set stores the written word with enable, fresh-start and the four freeze bits cleared. It also clears status, compare and count, sets load to 0xFFFFFFFF and enters HALT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fast_tick_en | input | 1 | Fast clock-enable pulse |
| slow_tick_en | input | 1 | Slow clock-enable pulse |
| irq | output | 1 | Level interrupt |

## Verification
The corners that are hardest to reach from the ports are the wrap from zero to all ones and the overwrite of the live count. Reaching either by plain counting would take billions of ticks. The stimulus therefore uses the immediate-overwrite path to drop the count to 1, so both corners can be driven in a few cycles. A compare flag raised while its interrupt enable is off is then turned on afterwards, which shows the gating of `irq`. A prescaler division is interrupted part way by a rewrite of the control word, which shows the restart.

// File: rtl/pit_pkg.sv
package pit_pkg;
    // register byte offsets
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_LOAD = 'h08;
    localparam int OFF_CMP  = 'h0C;
    localparam int OFF_CNT  = 'h10;

    // control word bit positions
    localparam int B_EN      = 0;
    localparam int B_FRESH   = 1;
    localparam int B_CMPIE   = 2;
    localparam int B_RELOAD  = 3;
    localparam int B_PRE_LSB = 4;
    localparam int B_SRST    = 16;
    localparam int B_OVW     = 17;
    localparam int B_FRZ_LSB = 18;
    localparam int B_SRC_LSB = 24;

    typedef enum logic {ST_HALT, ST_RUN} run_state_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler import pit_pkg::*; #(
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [1:0]         src_sel,
    input  logic               fast_tick_en,
    input  logic               slow_tick_en,
    input  logic [PRESC_W-1:0] div_val,
    input  logic               restart,
    input  logic [PRESC_W-1:0] restart_val,
    output logic               tick
);
    logic               src_tick;
    logic [PRESC_W-1:0] div_q;

    // source select: 00 none, 01/10 fast, 11 slow
    always_comb begin
        unique case (src_sel)
            2'b00:          src_tick = 1'b0;
            2'b01, 2'b10:   src_tick = fast_tick_en;
            default:        src_tick = slow_tick_en;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= restart_val;
        end else if (run && src_tick) begin
            div_q <= (div_q == '0) ? div_val : div_q - 1'b1;
        end
    end

    assign tick = run && src_tick && (div_q == '0);
endmodule

// File: rtl/pit_regs.sv
module pit_regs import pit_pkg::*; #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  count_val,
    input  logic               match_evt,
    output logic [DATA_W-1:0]  load_q,
    output logic [DATA_W-1:0]  cmp_q,
    output logic               flag_q,
    output logic               cmp_ie,
    output logic               reload_mode,
    output logic [1:0]         src_sel,
    output logic [PRESC_W-1:0] presc_val,
    output logic               ctrl_wr,
    output logic               start_req,
    output logic               stop_req,
    output logic               srst_req,
    output logic               ovw_req
);
    localparam logic [DATA_W-1:0] ONES     = '1;
    localparam logic [DATA_W-1:0] WR_MASK  =
        DATA_W'((64'd1 << (B_SRC_LSB + 2)) - 64'd1) & ~(DATA_W'(1) << B_SRST);
    localparam logic [DATA_W-1:0] SRST_CLR =
        (DATA_W'(1) << B_EN) | (DATA_W'(1) << B_FRESH) | (DATA_W'(4'hF) << B_FRZ_LSB);

    logic [DATA_W-1:0] ctrl_q;
    logic sel_ctrl, sel_stat, sel_load, sel_cmp, sel_cnt;
    logic stat_wr, load_wr, cmp_wr;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign sel_load = (bus_addr == ADDR_W'(OFF_LOAD));
    assign sel_cmp  = (bus_addr == ADDR_W'(OFF_CMP));
    assign sel_cnt  = (bus_addr == ADDR_W'(OFF_CNT));

    assign ctrl_wr  = bus_we && sel_ctrl;
    assign stat_wr  = bus_we && sel_stat;
    assign load_wr  = bus_we && sel_load;
    assign cmp_wr   = bus_we && sel_cmp;

    assign srst_req  = ctrl_wr && bus_wdata[B_SRST];
    assign start_req = ctrl_wr && !bus_wdata[B_SRST] && bus_wdata[B_EN] && !ctrl_q[B_EN];
    assign stop_req  = ctrl_wr && (bus_wdata[B_SRST] || !bus_wdata[B_EN]);
    assign ovw_req   = load_wr && ctrl_q[B_OVW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            load_q <= ONES;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else if (srst_req) begin
            ctrl_q <= bus_wdata & WR_MASK & ~SRST_CLR;
            load_q <= ONES;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata & WR_MASK;
            if (load_wr) load_q <= bus_wdata;
            if (cmp_wr)  cmp_q  <= bus_wdata;
            if (match_evt) begin
                flag_q <= 1'b1;
            end else if (stat_wr && bus_wdata[0]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_stat) bus_rdata = DATA_W'(flag_q);
        else if (sel_load) bus_rdata = load_q;
        else if (sel_cmp)  bus_rdata = cmp_q;
        else if (sel_cnt)  bus_rdata = count_val;
    end

    assign cmp_ie      = ctrl_q[B_CMPIE];
    assign reload_mode = ctrl_q[B_RELOAD];
    assign src_sel     = ctrl_q[B_SRC_LSB +: 2];
    assign presc_val   = ctrl_q[B_PRE_LSB +: PRESC_W];
endmodule

// File: rtl/pit_counter.sv
module pit_counter import pit_pkg::*; #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              srst_req,
    input  logic              ovw_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reload_mode,
    input  logic [DATA_W-1:0] load_val,
    input  logic [DATA_W-1:0] cmp_val,
    input  logic              tick,
    output logic [DATA_W-1:0] count_q,
    output logic              match_evt,
    output logic              running
);
    localparam logic [DATA_W-1:0] ONES = '1;

    run_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // transitions: START (HALT->RUN), STOP (RUN->HALT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (start_req) state_d = ST_RUN;
            ST_RUN:  if (stop_req)  state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // outputs: next count and compare event
    always_comb begin
        count_d   = count_q;
        match_evt = 1'b0;
        if (srst_req) begin
            count_d = '0;
        end else if (ovw_req) begin
            count_d = wr_data;
        end else if (start_req) begin
            if (wr_data[B_FRESH]) count_d = wr_data[B_RELOAD] ? load_val : ONES;
        end else if (state_q == ST_RUN && tick) begin
            if (count_q == '0) count_d = reload_mode ? load_val : ONES;
            else               count_d = count_q - 1'b1;
            match_evt = (count_d == cmp_val);
        end
    end

    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer import pit_pkg::*; #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fast_tick_en,
    input  logic              slow_tick_en,
    output logic              irq
);
    logic [DATA_W-1:0]  cnt_val, load_val, cmp_val;
    logic               flag, cmp_ie, reload_mode, match_evt, running, tick;
    logic [1:0]         src_sel;
    logic [PRESC_W-1:0] presc_val;
    logic               ctrl_wr, start_req, stop_req, srst_req, ovw_req;

    pit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count_val(cnt_val), .match_evt(match_evt),
        .load_q(load_val), .cmp_q(cmp_val), .flag_q(flag),
        .cmp_ie(cmp_ie), .reload_mode(reload_mode), .src_sel(src_sel), .presc_val(presc_val),
        .ctrl_wr(ctrl_wr), .start_req(start_req), .stop_req(stop_req),
        .srst_req(srst_req), .ovw_req(ovw_req)
    );

    pit_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(running), .src_sel(src_sel),
        .fast_tick_en(fast_tick_en), .slow_tick_en(slow_tick_en),
        .div_val(presc_val), .restart(ctrl_wr),
        .restart_val(bus_wdata[B_PRE_LSB +: PRESC_W]), .tick(tick)
    );

    pit_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .stop_req(stop_req), .srst_req(srst_req), .ovw_req(ovw_req),
        .wr_data(bus_wdata), .reload_mode(reload_mode),
        .load_val(load_val), .cmp_val(cmp_val), .tick(tick),
        .count_q(cnt_val), .match_evt(match_evt), .running(running)
    );

    assign irq = flag && cmp_ie;
endmodule

// File: rtl/pit_checker.sv
module pit_checker import pit_pkg::*; #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] load,
    input logic              flag,
    input logic              match_evt,
    input logic              tick
);
    logic a_ctrl, a_stat, a_load, a_cmp, a_cnt;
    assign a_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign a_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign a_load = (bus_addr == ADDR_W'(OFF_LOAD));
    assign a_cmp  = (bus_addr == ADDR_W'(OFF_CMP));
    assign a_cnt  = (bus_addr == ADDR_W'(OFF_CNT));

    // R2: unmapped offsets read as zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ctrl || a_stat || a_load || a_cmp || a_cnt) |-> (bus_rdata == '0));

    // R4: free-running wrap from zero
    p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !ctrl[B_RELOAD] && !bus_we) |=> (cnt == '1));

    // R7: disabled counter holds
    p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[B_EN] && !(bus_we && (a_ctrl || a_load))) |=> $stable(cnt));

    // R9: flag is sticky
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(bus_we && a_stat && bus_wdata[0]) && !(bus_we && a_ctrl && bus_wdata[B_SRST]))
        |=> flag);

    // R9: write-one clears the flag when no event competes
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a_stat && bus_wdata[0] && !match_evt) |=> !flag);

    // R11: soft reset effect
    p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && a_ctrl && bus_wdata[B_SRST])
        |=> (cnt == '0 && !flag && load == '1 && !ctrl[B_EN] && !ctrl[B_FRESH]));
endmodule

bind periodic_irq_timer pit_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(u_regs.ctrl_q),
    .cnt(cnt_val), .load(load_val), .flag(flag), .match_evt(match_evt), .tick(tick)
);

// File: tb/periodic_irq_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_irq_timer_tb_top;
    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_LOAD = 8'h08,
                           A_CMP = 8'h0C, A_CNT = 8'h10, A_BAD = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_tick_en = 1'b0;
    logic        slow_tick_en = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // scoreboard queues
    logic [31:0] exp_q[$];
    bit          kind_q[$];
    string       tag_q[$];
    event        smp;

    always #2.5 clk = ~clk;

    periodic_irq_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fast_tick_en(fast_tick_en), .slow_tick_en(slow_tick_en), .irq(irq)
    );

    // monitor: pops an expected item and compares with the port
    initial begin
        forever begin
            @(smp);
            while (exp_q.size() > 0) begin
                logic [31:0] e, a;
                bit k;
                string t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                a = k ? {31'b0, irq} : bus_rdata;
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h", t, k ? "irq" : "read", a, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
        #0.5 -> smp;
        #0.5;
    endtask

    task automatic exp_irq(input bit e, input string t);
        @(negedge clk);
        exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
        #0.5 -> smp;
        #0.5;
    endtask

    task automatic fast(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fast_tick_en = 1'b1;
            @(negedge clk); fast_tick_en = 1'b0;
        end
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick_en = 1'b1;
            @(negedge clk); slow_tick_en = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog all-reqs actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R2 unmapped read
        exp_rd(A_CTRL, 32'h0, "R1");
        exp_rd(A_STAT, 32'h0, "R1");
        exp_rd(A_LOAD, 32'hFFFF_FFFF, "R1");
        exp_rd(A_CMP,  32'h0, "R1");
        exp_rd(A_CNT,  32'h0, "R1");
        exp_irq(1'b0, "R1");
        exp_rd(A_BAD,  32'h0, "R2");

        // reload mode run, compare at zero
        bus_wr(A_LOAD, 32'd5);
        bus_wr(A_CTRL, 32'h0100_000F);
        exp_rd(A_CTRL, 32'h0100_000F, "R3");
        exp_rd(A_CNT, 32'd5, "R7");
        fast(3);
        exp_rd(A_CNT, 32'd2, "R4");
        exp_rd(A_STAT, 32'd0, "R9");
        fast(2);
        exp_rd(A_CNT, 32'd0, "R4");
        exp_rd(A_STAT, 32'd1, "R9");
        exp_irq(1'b1, "R10");
        bus_wr(A_STAT, 32'd0);
        exp_rd(A_STAT, 32'd1, "R9");
        fast(1);
        exp_rd(A_CNT, 32'd5, "R4");
        exp_rd(A_STAT, 32'd1, "R9");
        bus_wr(A_STAT, 32'd1);
        exp_rd(A_STAT, 32'd0, "R9");
        exp_irq(1'b0, "R10");

        // R5 source select
        slow(2);
        exp_rd(A_CNT, 32'd5, "R5");
        bus_wr(A_CTRL, 32'h0300_000F);
        exp_rd(A_CNT, 32'd5, "R7");
        fast(2);
        exp_rd(A_CNT, 32'd5, "R5");
        slow(1);
        exp_rd(A_CNT, 32'd4, "R5");
        bus_wr(A_CTRL, 32'h0000_000F);
        fast(2); slow(2);
        exp_rd(A_CNT, 32'd4, "R5");
        bus_wr(A_CTRL, 32'h0200_000F);
        fast(1);
        exp_rd(A_CNT, 32'd3, "R5");

        // R6 prescaler and restart
        bus_wr(A_CTRL, 32'h0100_002F);
        fast(2);
        exp_rd(A_CNT, 32'd3, "R6");
        fast(1);
        exp_rd(A_CNT, 32'd2, "R6");
        fast(2);
        bus_wr(A_CTRL, 32'h0100_002F);
        fast(2);
        exp_rd(A_CNT, 32'd2, "R6");
        fast(1);
        exp_rd(A_CNT, 32'd1, "R6");

        // R7 hold while disabled and resume
        bus_wr(A_CTRL, 32'h0100_000C);
        fast(3);
        exp_rd(A_CNT, 32'd1, "R7");
        bus_wr(A_CTRL, 32'h0100_000D);
        exp_rd(A_CNT, 32'd1, "R7");
        fast(1);
        exp_rd(A_CNT, 32'd0, "R7");
        exp_rd(A_STAT, 32'd1, "R9");
        bus_wr(A_STAT, 32'd1);

        // R7 fresh start without reload, R4 free run
        bus_wr(A_CTRL, 32'h0100_000C);
        bus_wr(A_CTRL, 32'h0100_0003);
        exp_rd(A_CNT, 32'hFFFF_FFFF, "R7");
        fast(1);
        exp_rd(A_CNT, 32'hFFFF_FFFE, "R4");

        // R8 overwrite
        bus_wr(A_LOAD, 32'd7);
        exp_rd(A_CNT, 32'hFFFF_FFFE, "R8");
        exp_rd(A_LOAD, 32'd7, "R8");
        bus_wr(A_CTRL, 32'h0102_0003);
        exp_rd(A_CNT, 32'hFFFF_FFFE, "R8");
        bus_wr(A_LOAD, 32'd1);
        exp_rd(A_CNT, 32'd1, "R8");
        fast(1);
        exp_rd(A_STAT, 32'd1, "R9");
        exp_irq(1'b0, "R10");
        fast(1);
        exp_rd(A_CNT, 32'hFFFF_FFFF, "R4");
        bus_wr(A_CTRL, 32'h0102_0007);
        exp_irq(1'b1, "R10");
        bus_wr(A_STAT, 32'd1);
        exp_irq(1'b0, "R10");

        // R9 nonzero compare
        bus_wr(A_CMP, 32'd3);
        bus_wr(A_CTRL, 32'h0102_000F);
        bus_wr(A_LOAD, 32'd5);
        exp_rd(A_CNT, 32'd5, "R8");
        fast(1);
        exp_rd(A_CNT, 32'd4, "R9");
        exp_rd(A_STAT, 32'd0, "R9");
        fast(1);
        exp_rd(A_STAT, 32'd1, "R9");
        exp_irq(1'b1, "R10");

        // R2 ignored writes
        bus_wr(A_BAD, 32'h0);
        bus_wr(A_CNT, 32'h55);
        exp_rd(A_CNT, 32'd3, "R2");
        exp_rd(A_CTRL, 32'h0102_000F, "R2");
        exp_rd(A_LOAD, 32'd5, "R2");
        exp_rd(A_CMP, 32'd3, "R2");

        // R11 soft reset, R3 mask
        bus_wr(A_CTRL, 32'hFF3F_007F);
        exp_rd(A_CTRL, 32'h0302_007C, "R11");
        exp_rd(A_STAT, 32'd0, "R11");
        exp_rd(A_LOAD, 32'hFFFF_FFFF, "R11");
        exp_rd(A_CMP, 32'd0, "R11");
        exp_rd(A_CNT, 32'd0, "R11");
        exp_irq(1'b0, "R11");
        slow(2);
        exp_rd(A_CNT, 32'd0, "R11");

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule